// File: doc/BRIEF.md
# LZW Cache-Line Compressor

This block compresses one cache line at a time with an LZW dictionary that is kept from one line to the next. Each stored dictionary entry is a pair: a 12-bit code pointing at a prefix string and one appended 8-bit symbol. Codes below 256 stand for single byte values and take no storage. The dictionary therefore learns across lines, and a line whose byte patterns were already seen comes out shorter.

A 256-bit line is handed over with `lineValid` while the block is idle. The block then walks the line byte by byte. At each step it scans the stored entries one per clock, looking for the current match extended by the next byte. On a hit it extends the match. On a miss it emits the current code, stores the extended string in the lowest free slot (if a slot is free), and restarts from the next byte. After the last byte it emits the remaining match. It then reports the packed size in bytes and whether the line falls under the size threshold that sends it to the compressed region of the cache.

Every stored entry used in a match is reported on a mark strobe with its index, so that an external reference-flag bank can record it.

Top module: `lzw_line_compressor`

## Requirements
- R1: After reset, `busy`, `codeValid`, `refMark` and `done` are low, and the dictionary holds no stored entries.
- R2: A line is accepted only when `lineValid` is high and `busy` is low. `lineValid` has no effect while `busy` is high. No code, mark or done appears while idle.
- R3: Emitted codes 0 to 255 mean the byte value itself. The stored entry at slot index i is emitted as code 256 + i.
- R4: At each step the block emits the code of the longest dictionary string matching the remaining input. It then stores (that code, next byte) in the lowest-index free slot, except after the final code of a line.
- R5: Byte k of the line is `lineData[8k+7:8k]`, and byte 0 is consumed first.
- R6: Stored entries persist from line to line until reset. Reset empties the dictionary.
- R7: When every slot is occupied, no entry is added and compression continues with the existing entries.
- R8: Each time a stored entry extends a match, `refMark` pulses for one cycle with `refIdx` equal to that slot index, in the order the matches occur.
- R9: `compSize` equals ceil(codeCount × 12 / 8) bytes, valid in the cycle `done` is high.
- R10: `compressible` is high with `done` exactly when `compSize` is below 16 bytes (ten codes or fewer).
- R11: `done` is a one-cycle pulse per accepted line, and the final code of the line appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lineValid | input | 1 | Offers a line for compression |
| lineData | input | 256 | Line bytes, byte k at bits 8k+7:8k |
| busy | output | 1 | High from acceptance through the done cycle |
| codeValid | output | 1 | An emitted code is present on `codeOut` |
| codeOut | output | 12 | Emitted code |
| refMark | output | 1 | A stored entry was used in a match |
| refIdx | output | 6 | Slot index of the used entry |
| done | output | 1 | Line finished; size and flag are valid |
| compSize | output | 6 | Compressed size in bytes |
| compressible | output | 1 | Size is below the threshold |

## Verification
The bench targets the threshold edge. Two lines differing only in their last bytes produce ten and eleven codes (15 and 17 bytes). A design that compares with less-or-equal, or drops the rounding, misclassifies one of them. Repeating an all-zero line checks persistence and exact code values: the second pass must shrink from eight codes to four. A design that clears the dictionary between lines, or numbers slots from zero, gives different codes. Once the dictionary is full, a line of unseen byte pairs sent twice must give 32 literal codes both times. A design that overwrites a slot would shorten the second pass. A line offered while busy must be ignored; a design that latches it would corrupt the result or pulse done twice.

// File: rtl/lzwc_pkg.sv
`timescale 1ns/1ps
package lzwc_pkg;
  localparam int SYM_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FINAL,
    ST_DONE
  } lzwc_state_t;

  typedef struct packed {
    logic load;
    logic scanStep;
    logic hitAdv;
    logic missAdv;
    logic emitFinal;
  } lzwc_ctrl_t;
endpackage

// File: rtl/lzwc_dict.sv
`timescale 1ns/1ps
module lzwc_dict #(
  parameter int CODE_W = 12,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [IDX_W-1:0]             rdIdx,
  output logic                         rdValid,
  output logic [CODE_W-1:0]            rdPrefix,
  output logic [lzwc_pkg::SYM_W-1:0]   rdSym,
  input  logic                         wrEn,
  input  logic [CODE_W-1:0]            wrPrefix,
  input  logic [lzwc_pkg::SYM_W-1:0]   wrSym
);
  logic [DEPTH-1:0]                 validQ;
  logic [CODE_W-1:0]                prefixMem [DEPTH];
  logic [lzwc_pkg::SYM_W-1:0]       symMem    [DEPTH];
  logic [IDX_W-1:0]                 freeIdx;
  logic                             isFull;

  // lowest free slot: scan from the top so the smallest index wins
  always_comb begin
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!validQ[i]) freeIdx = IDX_W'(i);
    end
  end

  assign isFull = &validQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
    end else if (wrEn && !isFull) begin
      validQ[freeIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn && !isFull) begin
      prefixMem[freeIdx] <= wrPrefix;
      symMem[freeIdx]    <= wrSym;
    end
  end

  assign rdValid  = validQ[rdIdx];
  assign rdPrefix = prefixMem[rdIdx];
  assign rdSym    = symMem[rdIdx];
endmodule

// File: rtl/lzwc_ctrl.sv
`timescale 1ns/1ps
module lzwc_ctrl (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lineValid,
  input  logic                 scanHit,
  input  logic                 scanLast,
  input  logic                 lastPos,
  output lzwc_pkg::lzwc_ctrl_t ctrl,
  output logic                 busy,
  output logic                 done
);
  import lzwc_pkg::*;

  lzwc_state_t stateQ, stateNext;

  always_comb begin
    ctrl      = '0;
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (lineValid) begin
          ctrl.load = 1'b1;
          stateNext = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (scanHit) begin
          ctrl.hitAdv = 1'b1;
          if (lastPos) stateNext = ST_FINAL;
        end else if (scanLast) begin
          ctrl.missAdv = 1'b1;
          if (lastPos) stateNext = ST_FINAL;
        end else begin
          ctrl.scanStep = 1'b1;
        end
      end
      ST_FINAL: begin
        ctrl.emitFinal = 1'b1;
        stateNext      = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateNext;
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = (stateQ == ST_DONE);
endmodule

// File: rtl/lzwc_datapath.sv
`timescale 1ns/1ps
module lzwc_datapath #(
  parameter int LINE_BYTES   = 32,
  parameter int CODE_W       = 12,
  parameter int DEPTH        = 64,
  parameter int THRESH_BYTES = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int SIZE_W = $clog2(LINE_BYTES * CODE_W / 8 + 1)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  lzwc_pkg::lzwc_ctrl_t             ctrl,
  input  logic [LINE_BYTES*8-1:0]          lineData,
  output logic [IDX_W-1:0]                 scanIdx,
  input  logic                             rdValid,
  input  logic [CODE_W-1:0]                rdPrefix,
  input  logic [lzwc_pkg::SYM_W-1:0]       rdSym,
  output logic                             wrEn,
  output logic [CODE_W-1:0]                wrPrefix,
  output logic [lzwc_pkg::SYM_W-1:0]       wrSym,
  output logic                             scanHit,
  output logic                             scanLast,
  output logic                             lastPos,
  output logic                             codeValid,
  output logic [CODE_W-1:0]                codeOut,
  output logic                             refMark,
  output logic [IDX_W-1:0]                 refIdx,
  output logic [SIZE_W-1:0]                compSize,
  output logic                             compressible
);
  localparam int POS_W  = $clog2(LINE_BYTES);
  localparam int CNT_W  = $clog2(LINE_BYTES + 1);
  localparam int BITS_W = $clog2(LINE_BYTES * CODE_W + 8) + 1;
  localparam logic [CODE_W-1:0] BASE = CODE_W'(1 << lzwc_pkg::SYM_W);

  logic [LINE_BYTES*8-1:0]        lineQ;
  logic [POS_W-1:0]               posQ;
  logic [CODE_W-1:0]              curQ;
  logic [IDX_W-1:0]               idxQ;
  logic [CNT_W-1:0]               cntQ;
  logic [lzwc_pkg::SYM_W-1:0]     nextSym;
  logic [BITS_W-1:0]              bitsTotal;
  logic [BITS_W-1:0]              bytesWide;

  assign nextSym  = lineQ[{posQ, 3'b000} +: 8];
  assign scanIdx  = idxQ;
  assign scanHit  = rdValid && (rdPrefix == curQ) && (rdSym == nextSym);
  assign scanLast = (idxQ == IDX_W'(DEPTH - 1));
  assign lastPos  = (posQ == POS_W'(LINE_BYTES - 1));

  assign wrEn     = ctrl.missAdv;
  assign wrPrefix = curQ;
  assign wrSym    = nextSym;

  always_ff @(posedge clk) begin
    if (rst) begin
      lineQ     <= '0;
      posQ      <= '0;
      curQ      <= '0;
      idxQ      <= '0;
      cntQ      <= '0;
      codeValid <= 1'b0;
      codeOut   <= '0;
      refMark   <= 1'b0;
      refIdx    <= '0;
    end else begin
      codeValid <= 1'b0;
      refMark   <= 1'b0;
      if (ctrl.load) begin
        lineQ <= lineData;
        curQ  <= CODE_W'(lineData[7:0]);
        posQ  <= POS_W'(1);
        idxQ  <= '0;
        cntQ  <= '0;
      end
      if (ctrl.scanStep) idxQ <= idxQ + 1'b1;
      if (ctrl.hitAdv) begin
        curQ    <= BASE + CODE_W'(idxQ);
        idxQ    <= '0;
        posQ    <= posQ + 1'b1;
        refMark <= 1'b1;
        refIdx  <= idxQ;
      end
      if (ctrl.missAdv) begin
        codeValid <= 1'b1;
        codeOut   <= curQ;
        cntQ      <= cntQ + 1'b1;
        curQ      <= CODE_W'(nextSym);
        idxQ      <= '0;
        posQ      <= posQ + 1'b1;
      end
      if (ctrl.emitFinal) begin
        codeValid <= 1'b1;
        codeOut   <= curQ;
        cntQ      <= cntQ + 1'b1;
      end
    end
  end

  assign bitsTotal    = BITS_W'(cntQ) * BITS_W'(CODE_W);
  assign bytesWide    = (bitsTotal + BITS_W'(7)) >> 3;
  assign compSize     = SIZE_W'(bytesWide);
  assign compressible = (compSize < SIZE_W'(THRESH_BYTES));
endmodule

// File: rtl/lzw_line_compressor.sv
`timescale 1ns/1ps
module lzw_line_compressor #(
  parameter int LINE_BYTES   = 32,
  parameter int CODE_W       = 12,
  parameter int DICT_DEPTH   = 64,
  parameter int THRESH_BYTES = 16
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          lineValid,
  input  logic [LINE_BYTES*8-1:0]                       lineData,
  output logic                                          busy,
  output logic                                          codeValid,
  output logic [CODE_W-1:0]                             codeOut,
  output logic                                          refMark,
  output logic [$clog2(DICT_DEPTH)-1:0]                 refIdx,
  output logic                                          done,
  output logic [$clog2(LINE_BYTES*CODE_W/8+1)-1:0]      compSize,
  output logic                                          compressible
);
  localparam int IDX_W = $clog2(DICT_DEPTH);

  lzwc_pkg::lzwc_ctrl_t             ctrl;
  logic [IDX_W-1:0]                 scanIdx;
  logic                             rdValid;
  logic [CODE_W-1:0]                rdPrefix;
  logic [lzwc_pkg::SYM_W-1:0]       rdSym;
  logic                             wrEn;
  logic [CODE_W-1:0]                wrPrefix;
  logic [lzwc_pkg::SYM_W-1:0]       wrSym;
  logic                             scanHit;
  logic                             scanLast;
  logic                             lastPos;

  lzwc_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .lineValid(lineValid),
    .scanHit  (scanHit),
    .scanLast (scanLast),
    .lastPos  (lastPos),
    .ctrl     (ctrl),
    .busy     (busy),
    .done     (done)
  );

  lzwc_datapath #(
    .LINE_BYTES  (LINE_BYTES),
    .CODE_W      (CODE_W),
    .DEPTH       (DICT_DEPTH),
    .THRESH_BYTES(THRESH_BYTES)
  ) dp_i (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .lineData    (lineData),
    .scanIdx     (scanIdx),
    .rdValid     (rdValid),
    .rdPrefix    (rdPrefix),
    .rdSym       (rdSym),
    .wrEn        (wrEn),
    .wrPrefix    (wrPrefix),
    .wrSym       (wrSym),
    .scanHit     (scanHit),
    .scanLast    (scanLast),
    .lastPos     (lastPos),
    .codeValid   (codeValid),
    .codeOut     (codeOut),
    .refMark     (refMark),
    .refIdx      (refIdx),
    .compSize    (compSize),
    .compressible(compressible)
  );

  lzwc_dict #(
    .CODE_W(CODE_W),
    .DEPTH (DICT_DEPTH)
  ) dict_i (
    .clk     (clk),
    .rst     (rst),
    .rdIdx   (scanIdx),
    .rdValid (rdValid),
    .rdPrefix(rdPrefix),
    .rdSym   (rdSym),
    .wrEn    (wrEn),
    .wrPrefix(wrPrefix),
    .wrSym   (wrSym)
  );
endmodule

// File: rtl/lzw_line_compressor_chk.sv
`timescale 1ns/1ps
module lzw_line_compressor_chk #(
  parameter int LINE_BYTES   = 32,
  parameter int CODE_W       = 12,
  parameter int DICT_DEPTH   = 64,
  parameter int SIZE_W       = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              lineValid,
  input logic              busy,
  input logic              codeValid,
  input logic [CODE_W-1:0] codeOut,
  input logic              refMark,
  input logic              done,
  input logic [SIZE_W-1:0] compSize
);
  localparam int MAX_BYTES = LINE_BYTES * CODE_W / 8;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_WITH_CODE: assert property (@(posedge clk) disable iff (rst)
    done |-> codeValid); // R11
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    codeValid |-> (int'(codeOut) < 256 + DICT_DEPTH)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!codeValid && !refMark && !done)); // R2
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(lineValid)); // R2
  AST_MARK_APART: assert property (@(posedge clk) disable iff (rst)
    refMark |-> !codeValid); // R8
  AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(compSize) <= MAX_BYTES && int'(compSize) >= (CODE_W + 7) / 8)); // R9
endmodule

bind lzw_line_compressor lzw_line_compressor_chk #(
  .LINE_BYTES(LINE_BYTES),
  .CODE_W    (CODE_W),
  .DICT_DEPTH(DICT_DEPTH),
  .SIZE_W    ($clog2(LINE_BYTES*CODE_W/8+1))
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .lineValid(lineValid),
  .busy     (busy),
  .codeValid(codeValid),
  .codeOut  (codeOut),
  .refMark  (refMark),
  .done     (done),
  .compSize (compSize)
);

// File: tb/lzw_line_compressor_tb_top.sv
`timescale 1ns/1ps
module lzw_line_compressor_tb_top;
  localparam int LB = 32;
  localparam int CW = 12;
  localparam int DD = 64;
  localparam int TH = 16;
  localparam int LW = LB * 8;
  localparam int NV = 5;

  localparam logic [LW-1:0] VEC [NV] = '{
    {16{16'h6261}},
    {8{32'hDEADBEEF}},
    256'h1F1E1D1C1B1A191817161514131211100F0E0D0C0B0A09080706050403020100,
    {4{64'h0011223344556677}},
    {16{16'h6261}}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineValid = 1'b0;
  logic [LW-1:0] lineData = '0;
  logic busy, codeValid, refMark, done, compressible;
  logic [CW-1:0] codeOut;
  logic [5:0] refIdx;
  logic [5:0] compSize;

  always #2.5 clk = ~clk;

  lzw_line_compressor dut_i (
    .clk(clk), .rst(rst), .lineValid(lineValid), .lineData(lineData),
    .busy(busy), .codeValid(codeValid), .codeOut(codeOut),
    .refMark(refMark), .refIdx(refIdx), .done(done),
    .compSize(compSize), .compressible(compressible)
  );

  int checks = 0;
  int errors = 0;

  int gotCodes [64];
  int gotCount;
  int gotMarks [64];
  int gotMarkCount;
  int doneCount;
  int gotSize;
  bit gotComp;

  int  mPre [DD];
  int  mSym [DD];
  bit  mValid [DD];
  int  expCodes [64];
  int  expCount;
  int  expMarks [64];
  int  expMarkCount;

  always @(negedge clk) begin
    if (!rst) begin
      if (codeValid) begin
        if (gotCount < 64) gotCodes[gotCount] = int'(codeOut);
        gotCount++;
      end
      if (refMark) begin
        if (gotMarkCount < 64) gotMarks[gotMarkCount] = int'(refIdx);
        gotMarkCount++;
      end
      if (done) begin
        doneCount++;
        gotSize = int'(compSize);
        gotComp = compressible;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < DD; i++) mValid[i] = 1'b0;
  endtask

  function automatic bit modelFull();
    for (int i = 0; i < DD; i++) if (!mValid[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic modelLine(input logic [LW-1:0] line);
    int cur;
    expCount = 0;
    expMarkCount = 0;
    cur = int'(line[7:0]);
    for (int p = 1; p < LB; p++) begin
      int s;
      int found;
      s = int'(line[8*p +: 8]);
      found = -1;
      for (int i = 0; i < DD; i++) begin
        if (found < 0 && mValid[i] && mPre[i] == cur && mSym[i] == s) found = i;
      end
      if (found >= 0) begin
        expMarks[expMarkCount] = found;
        expMarkCount++;
        cur = 256 + found;
      end else begin
        int freeSlot;
        expCodes[expCount] = cur;
        expCount++;
        freeSlot = -1;
        for (int i = DD - 1; i >= 0; i--) if (!mValid[i]) freeSlot = i;
        if (freeSlot >= 0) begin
          mValid[freeSlot] = 1'b1;
          mPre[freeSlot] = cur;
          mSym[freeSlot] = s;
        end
        cur = s;
      end
    end
    expCodes[expCount] = cur;
    expCount++;
  endtask

  task automatic waitDone();
    while (doneCount == 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendLine(input logic [LW-1:0] line);
    gotCount = 0;
    gotMarkCount = 0;
    doneCount = 0;
    @(negedge clk);
    lineValid = 1'b1;
    lineData = line;
    @(negedge clk);
    lineValid = 1'b0;
    waitDone();
  endtask

  task automatic sendWithNoise(input logic [LW-1:0] line, input logic [LW-1:0] noise);
    gotCount = 0;
    gotMarkCount = 0;
    doneCount = 0;
    @(negedge clk);
    lineValid = 1'b1;
    lineData = line;
    @(negedge clk);
    lineValid = 1'b0;
    repeat (12) @(negedge clk);
    lineValid = 1'b1;
    lineData = noise;
    @(negedge clk);
    lineValid = 1'b0;
    lineData = line;
    waitDone();
  endtask

  task automatic compareLine(input logic [LW-1:0] line);
    int firstBad;
    int expSize;
    modelLine(line);
    sendLine(line);
    expSize = (expCount * CW + 7) / 8;
    check(gotCount == expCount, "R4", "code count", gotCount, expCount);
    firstBad = -1;
    for (int i = 0; i < expCount && i < gotCount; i++)
      if (firstBad < 0 && gotCodes[i] != expCodes[i]) firstBad = i;
    check(firstBad < 0, "R4", "code sequence",
          firstBad < 0 ? 0 : gotCodes[firstBad], firstBad < 0 ? 0 : expCodes[firstBad]);
    check(gotMarkCount == expMarkCount, "R8", "mark count", gotMarkCount, expMarkCount);
    firstBad = -1;
    for (int i = 0; i < expMarkCount && i < gotMarkCount; i++)
      if (firstBad < 0 && gotMarks[i] != expMarks[i]) firstBad = i;
    check(firstBad < 0, "R8", "mark index",
          firstBad < 0 ? 0 : gotMarks[firstBad], firstBad < 0 ? 0 : expMarks[firstBad]);
    check(gotSize == expSize, "R9", "size bytes", gotSize, expSize);
    check(gotComp == (expSize < TH), "R10", "compressible", int'(gotComp), int'(expSize < TH));
    check(doneCount == 1, "R11", "done pulses", doneCount, 1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelReset();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [LW-1:0] incLine;
    logic [LW-1:0] pairLine;
    logic [LW-1:0] lineA;
    logic [LW-1:0] lineB;
    int firstPassCount;
    for (int j = 0; j < LB; j++) incLine[8*j +: 8] = 8'(j);
    pairLine = {16{16'hC1C0}};
    lineA = {32'h01010101, 224'h0};
    lineB = {32'h04030201, 224'h0};

    gotCount = 0; gotMarkCount = 0; doneCount = 0;
    doReset();

    // R1 reset state
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(codeValid == 1'b0, "R1", "codeValid after reset", int'(codeValid), 0);
    check(done == 1'b0 && refMark == 1'b0, "R1", "done/mark after reset", int'(done), 0);

    // R1 R3: empty dictionary, zero line gives 0,256..261,258
    compareLine('0);
    check(gotCount == 8, "R1", "zero line codes", gotCount, 8);
    check(gotCodes[0] == 0, "R3", "first literal", gotCodes[0], 0);
    check(gotCodes[1] == 256, "R3", "first stored code", gotCodes[1], 256);
    check(gotCodes[7] == 258, "R3", "final code", gotCodes[7], 258);
    check(gotSize == 12, "R9", "zero line size", gotSize, 12);

    // R6 persistence: same line shrinks to 262,263,264,259
    compareLine('0);
    check(gotCount == 4, "R6", "second zero line codes", gotCount, 4);
    check(gotCodes[0] == 262 && gotCodes[3] == 259, "R6", "learned codes", gotCodes[0], 262);

    // R5 byte order
    compareLine(incLine);
    check(gotCodes[1] == 1 && gotCodes[31] == 31, "R5", "byte order", gotCodes[31], 31);

    // table walk
    for (int v = 0; v < NV; v++) compareLine(VEC[v]);

    // fill the dictionary (R7)
    for (int n = 0; n < 8 && !modelFull(); n++) begin
      logic [LW-1:0] fillLine;
      for (int j = 0; j < LB; j++) fillLine[8*j +: 8] = 8'((n * 32 + 40 + j) & 8'h7F);
      compareLine(fillLine);
    end
    check(modelFull(), "R7", "dictionary filled", int'(modelFull()), 1);
    compareLine(pairLine);
    firstPassCount = gotCount;
    check(firstPassCount == 32, "R7", "full dict first pass", firstPassCount, 32);
    compareLine(pairLine);
    check(gotCount == 32, "R7", "full dict no learning", gotCount, 32);

    // R2 line offered while busy is ignored
    modelLine(VEC[1]);
    sendWithNoise(VEC[1], {32{8'h55}});
    check(gotCount == expCount, "R2", "noise code count", gotCount, expCount);
    check(gotCodes[0] == expCodes[0], "R2", "noise first code", gotCodes[0], expCodes[0]);
    repeat (6) @(negedge clk);
    check(busy == 1'b0 && doneCount == 1, "R2", "no second start", doneCount, 1);

    // R6 R10 threshold: ten codes -> 15 bytes, compressible
    doReset();
    compareLine(lineA);
    check(gotCount == 10, "R6", "line A codes after reset", gotCount, 10);
    check(gotSize == 15 && gotComp == 1'b1, "R10", "line A below threshold", gotSize, 15);

    // R10 eleven codes -> 17 bytes, not compressible
    doReset();
    compareLine(lineB);
    check(gotCount == 11, "R4", "line B codes", gotCount, 11);
    check(gotSize == 17 && gotComp == 1'b0, "R10", "line B above threshold", gotSize, 17);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule